// File: doc/BRIEF.md
# Sliced Parallel Integer Multiplier

This block forms the full double-width product of two unsigned integers of width M = SLICES * SLICE_W bits. Operand A is cut into SLICES digits of SLICE_W bits each, so A is read as a number in base 2^SLICE_W. Operand B is used at its full width. Each digit feeds its own slice multiplier, and all slice multipliers work in the same cycle. Each slice result is moved to its digit weight by a fixed wire shift of i * SLICE_W bits. The weighted results are then summed by a registered pairwise adder tree.

In each tree stage, entry j is added to entry j + h, where h is half the current entry count rounded up. When the count is odd, the entry left without a partner passes through that stage unchanged. The tree therefore takes ceil(log2 SLICES) stages for any slice count. A pipeline register sits after the slice multipliers and after every tree stage, so a result leaves a fixed number of cycles after its operands enter, and a new operand pair can enter on every cycle. The interface is a valid strobe on the way in and a valid strobe on the way out.

Top module: `mulslice_top`

## Requirements
- R1: When outValid is high, outProd equals inA * inB of the operand pair whose result is due in that cycle, as an unsigned product exactly 2*M bits wide.
- R2: outValid is high exactly 1 + ceil(log2 SLICES) clock cycles after the cycle in which inValid was sampled high. That is 3 cycles for SLICES = 4 and 4 cycles for SLICES = 6.
- R3: Operand pairs presented on consecutive cycles each produce their own correct result, in order, on consecutive cycles.
- R4: In any cycle whose matching input cycle had inValid low, outValid is low.
- R5: While rst_n is low, outValid is 0 and outProd is all zeros.
- R6: While outValid is low, outProd keeps the last product it delivered, or zero if none has been delivered since reset.
- R7: A slice count that is not a power of two (for example 6) gives correct products. The unpaired partial sums pass through a stage unchanged.
- R8: All-ones operands give the full product (2^M - 1)^2 with no truncation. A zero operand gives zero.
- R9: An A that is nonzero in only one digit i gives that digit times B, shifted left by i * SLICE_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair on inA/inB is valid this cycle |
| inA | input | SLICES*SLICE_W | Sliced operand (digit i is bits i*SLICE_W upward) |
| inB | input | SLICES*SLICE_W | Whole operand |
| outValid | output | 1 | outProd carries a new product this cycle |
| outProd | output | 2*SLICES*SLICE_W | Unsigned product |

## Verification
The bench builds two copies of the block side by side. The first has four slices of 8 bits, which makes a balanced tree two stages deep. The second has six slices of 5 bits, which makes an unbalanced three-stage tree in which odd entries pass through a stage on their own. Both copies receive the same valid pattern: back-to-back streams, sparse and gapped streams, extreme operands and single-digit operands. Running both copies together checks the pass-through path, the two different latencies and digit alignment at two slice widths in one run.

// File: rtl/mulslice_pkg.sv
package mulslice_pkg;

  localparam int MAX_STAGES = 8;

  typedef struct packed {
    logic [MAX_STAGES:0] load;
  } stageStrobe_t;

  function automatic int treeDepth(input int slices);
    return $clog2(slices);
  endfunction

  function automatic int levelCount(input int slices, input int level);
    int n;
    n = slices;
    for (int i = 0; i < level; i++) n = (n + 1) / 2;
    return n;
  endfunction

endpackage

// File: rtl/mulslice_unit.sv
module mulslice_unit #(
  parameter int SLICE_W = 8,
  parameter int OP_W    = 32
) (
  input  logic [SLICE_W-1:0]      aSlice,
  input  logic [OP_W-1:0]         bFull,
  output logic [SLICE_W+OP_W-1:0] prod
);
  localparam int PW = SLICE_W + OP_W;
  assign prod = PW'(aSlice) * PW'(bFull);
endmodule

// File: rtl/mulslice_ctrl.sv
module mulslice_ctrl
  import mulslice_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);
  logic [STAGES:0] validPipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validPipe <= '0;
    end else begin
      validPipe[0] <= inValid;
      for (int k = 1; k <= STAGES; k++) validPipe[k] <= validPipe[k-1];
    end
  end

  always_comb begin
    strobe = '0;
    strobe.load[0] = inValid;
    for (int k = 1; k <= STAGES; k++) strobe.load[k] = validPipe[k-1];
  end

  assign outValid = validPipe[STAGES];
endmodule

// File: rtl/mulslice_dp.sv
module mulslice_dp
  import mulslice_pkg::*;
#(
  parameter int SLICES  = 4,
  parameter int SLICE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  stageStrobe_t                  strobe,
  input  logic [SLICES*SLICE_W-1:0]     opA,
  input  logic [SLICES*SLICE_W-1:0]     opB,
  output logic [2*SLICES*SLICE_W-1:0]   prod
);
  localparam int OP_W   = SLICES * SLICE_W;
  localparam int PW     = 2 * OP_W;
  localparam int STAGES = treeDepth(SLICES);

  logic [SLICES-1:0][PW-1:0] sliceProd;
  logic [STAGES:0][SLICES-1:0][PW-1:0] lvl;
  logic unusedLoad;
  logic unusedLvl;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    logic [SLICE_W+OP_W-1:0] raw;
    logic [PW-1:0] ext;
    mulslice_unit #(.SLICE_W(SLICE_W), .OP_W(OP_W)) u_unit (
      .aSlice(opA[i*SLICE_W +: SLICE_W]),
      .bFull (opB),
      .prod  (raw)
    );
    assign ext = PW'(raw);
    assign sliceProd[i] = ext << (i * SLICE_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= '0;
    end else begin
      if (strobe.load[0]) lvl[0] <= sliceProd;
      for (int k = 1; k <= STAGES; k++) begin
        if (strobe.load[k]) begin
          for (int j = 0; j < SLICES; j++) begin
            if (j < (levelCount(SLICES, k-1) + 1) / 2) begin
              if (j + (levelCount(SLICES, k-1) + 1) / 2 < levelCount(SLICES, k-1))
                lvl[k][j] <= lvl[k-1][j] + lvl[k-1][j + (levelCount(SLICES, k-1) + 1) / 2];
              else
                lvl[k][j] <= lvl[k-1][j];
            end else begin
              lvl[k][j] <= '0;
            end
          end
        end
      end
    end
  end

  assign prod       = lvl[STAGES][0];
  assign unusedLoad = ^strobe.load;
  assign unusedLvl  = ^lvl;
endmodule

// File: rtl/mulslice_top.sv
module mulslice_top
  import mulslice_pkg::*;
#(
  parameter int SLICES  = 4,
  parameter int SLICE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inValid,
  input  logic [SLICES*SLICE_W-1:0]   inA,
  input  logic [SLICES*SLICE_W-1:0]   inB,
  output logic                        outValid,
  output logic [2*SLICES*SLICE_W-1:0] outProd
);
  localparam int STAGES = treeDepth(SLICES);

  stageStrobe_t strobe;

  mulslice_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  mulslice_dp #(.SLICES(SLICES), .SLICE_W(SLICE_W)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .opA   (inA),
    .opB   (inB),
    .prod  (outProd)
  );
endmodule

// File: rtl/mulslice_chk.sv
module mulslice_chk
  import mulslice_pkg::*;
#(
  parameter int SLICES  = 4,
  parameter int SLICE_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        inValid,
  input logic [SLICES*SLICE_W-1:0]   inA,
  input logic [SLICES*SLICE_W-1:0]   inB,
  input logic                        outValid,
  input logic [2*SLICES*SLICE_W-1:0] outProd
);
  localparam int PW  = 2 * SLICES * SLICE_W;
  localparam int LAT = 1 + treeDepth(SLICES);

  logic [LAT-1:0] validShadow;
  logic [LAT-1:0][PW-1:0] prodShadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validShadow <= '0;
      prodShadow  <= '0;
    end else begin
      validShadow[0] <= inValid;
      prodShadow[0]  <= PW'(inA) * PW'(inB);
      for (int i = 1; i < LAT; i++) begin
        validShadow[i] <= validShadow[i-1];
        prodShadow[i]  <= prodShadow[i-1];
      end
    end
  end

  // R2, R4: output strobe tracks the input strobe delayed by the pipeline depth
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid == validShadow[LAT-1]);

  // R1: delivered product matches the arithmetic product of its operands
  p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outProd == prodShadow[LAT-1]);

  // R6: output word does not move between deliveries
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> $stable(outProd));

  // R5: reset clears the outputs
  p_reset_r5: assert property (@(posedge clk)
    !rst_n |-> (!outValid && outProd == '0));
endmodule

bind mulslice_top mulslice_chk #(.SLICES(SLICES), .SLICE_W(SLICE_W)) u_chk (.*);

// File: tb/sim_mulslice_top.sv
`timescale 1ns/1ps
module sim_mulslice_top;
  localparam int S0 = 4, W0 = 8, M0 = 32, LAT0 = 3;
  localparam int S1 = 6, W1 = 5, M1 = 30, LAT1 = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic v = 1'b0;
  logic [M0-1:0] a0 = '0, b0 = '0;
  logic [M1-1:0] a1 = '0, b1 = '0;
  logic ov0, ov1;
  logic [2*M0-1:0] op0;
  logic [2*M1-1:0] op1;

  int passCount = 0;
  int failCount = 0;
  longint edgeCount = 0;
  string tag = "R1";

  typedef struct {
    longint due;
    logic [63:0] p;
  } exp_t;
  exp_t q0[$];
  exp_t q1[$];
  logic [63:0] last0 = '0;
  logic [63:0] last1 = '0;

  always #2 clk = ~clk;

  mulslice_top #(.SLICES(S0), .SLICE_W(W0)) u0 (
    .clk(clk), .rst_n(rst_n), .inValid(v), .inA(a0), .inB(b0),
    .outValid(ov0), .outProd(op0));

  mulslice_top #(.SLICES(S1), .SLICE_W(W1)) u1 (
    .clk(clk), .rst_n(rst_n), .inValid(v), .inA(a1), .inB(b1),
    .outValid(ov1), .outProd(op1));

  task automatic summary();
    $display("%0d/%0d checks passed", passCount, passCount + failCount);
  endtask

  always @(posedge clk) begin
    edgeCount++;
    if (edgeCount > 100000) begin
      failCount++;
      $display("FAIL watchdog: run hung, actual %0d edges expected fewer", edgeCount);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    if (ok) passCount++;
    else begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmp(ref exp_t q[$], ref logic [63:0] last, input logic ov,
                     input logic [63:0] op, input string pre);
    if (q.size() > 0 && q[0].due == edgeCount) begin
      check(ov == 1'b1, {pre, "R2 valid due"}, 64'(ov), 64'd1);
      check(op == q[0].p, {pre, tag, " product"}, op, q[0].p);
      last = q[0].p;
      void'(q.pop_front());
    end else begin
      check(ov == 1'b0, {pre, "R4 no valid"}, 64'(ov), 64'd0);
      check(op == last, {pre, "R6 hold"}, op, last);
    end
  endtask

  task automatic step(input bit vin, input logic [63:0] ain, input logic [63:0] bin);
    exp_t e;
    @(negedge clk);
    cmp(q0, last0, ov0, 64'(op0), "");
    cmp(q1, last1, ov1, 64'(op1), "R7 ");
    v  = vin;
    a0 = ain[M0-1:0];
    b0 = bin[M0-1:0];
    a1 = ain[M1-1:0];
    b1 = bin[M1-1:0];
    if (vin) begin
      e.due = edgeCount + LAT0;
      e.p   = 64'(a0) * 64'(b0);
      q0.push_back(e);
      e.due = edgeCount + LAT1;
      e.p   = 64'(a1) * 64'(b1);
      q1.push_back(e);
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(ov0 == 1'b0 && op0 == '0, "R5 reset u0", 64'(op0), 64'd0);
      check(ov1 == 1'b0 && op1 == '0, "R5 reset u1", 64'(op1), 64'd0);
    end
    rst_n = 1'b1;

    tag = "R1";
    step(1'b1, 64'h0000_0000_1234_5678, 64'h0000_0000_0abc_def1);
    for (int i = 0; i < 6; i++) step(1'b0, '0, '0);

    tag = "R3";
    for (int i = 0; i < 40; i++) step(1'b1, {$urandom(), $urandom()}, {$urandom(), $urandom()});

    tag = "R4";
    for (int i = 0; i < 30; i++) step(i % 3 == 0, {$urandom(), $urandom()}, {$urandom(), $urandom()});

    tag = "R8";
    step(1'b1, '1, '1);
    step(1'b1, '1, 64'd1);
    step(1'b1, '0, '1);
    step(1'b1, '1, '0);
    step(1'b0, '0, '0);
    step(1'b1, '1, '1);

    tag = "R9";
    for (int i = 0; i < 6; i++) begin
      logic [63:0] d;
      d = 64'(($urandom() % 31) + 1);
      step(1'b1, d << (i * W1), {$urandom(), $urandom()});
      step(1'b1, d << (i * W0), {$urandom(), $urandom()});
    end

    tag = "R1";
    for (int i = 0; i < 8; i++) step(1'b0, '0, '0);
    check(q0.size() == 0, "R2 drained u0", 64'(q0.size()), 64'd0);
    check(q1.size() == 0, "R7 drained u1", 64'(q1.size()), 64'd0);
    summary();
    $finish;
  end
endmodule